// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Almost-Empty / Almost-Full Thresholds

This block is a single-clock, 512-word by 9-bit first-in first-out buffer. Besides empty and full it reports two early-warning flags. Almost-empty is raised when the stored word count has dropped to a programmable level. Almost-full is raised when the remaining free space has dropped to a programmable margin. Both thresholds are 9-bit values, each split into a low byte and a high part.

The thresholds are not reached through a separate register bus. They sit in four byte-wide threshold slots, and those slots are written and read through the FIFO's own data ports. A dedicated active-low load pin, which also serves as the second write enable, switches both ports into threshold mode. In threshold mode each write or read visits one slot and then moves a circular slot selector on to the next. The slot order is empty-threshold low, empty-threshold high, full-threshold low, full-threshold high, and after the last slot the selector returns to the first. A host may program every slot in one burst, or a few slots at a time. The selector keeps its position between bursts, so the next access carries on where the last one stopped.

Top module: `pflag_fifo`

## Requirements
- R1: After a synchronous reset: `empty`=1, `full`=0, `almost_empty`=1, `almost_full`=0 and `dout`=0. Both thresholds equal 7 (low slot 0x07, high slot 0). The slot selector points at the empty-threshold low slot.
- R2: With `wr_ld_n`=1, a write (`wr_en_n`=0) stores `din` when the FIFO is not full. A read (`rd_en_a_n`=0 and `rd_en_b_n`=0) presents the oldest word on `dout` after the clock edge that accepts it, when the FIFO is not empty. Words leave in the order they were written.
- R3: A write while full is ignored and leaves stored data intact. A read while empty is ignored, and `dout` holds its value.
- R4: `empty` is 1 exactly when the count is 0. `full` is 1 exactly when the count is 512. Both flags are updated at the same edge as the count.
- R5: `almost_empty` is 1 when count <= E, where E = {empty-high bit 0, empty-low byte}.
- R6: `almost_full` is 1 when count >= 512 - F, where F = {full-high bit 0, full-low byte}.
- R7: With `wr_ld_n`=0 and `wr_en_n`=0, each edge writes into the selected slot and advances the selector. A low slot takes `din[7:0]` and a high slot takes `din[0]`. The order is empty-low(0), empty-high(1), full-low(2), full-high(3), and the fifth write lands in empty-low again.
- R8: Raising `wr_ld_n` partway through the sequence keeps the selector where it is. The next threshold access goes to the following slot, not back to empty-low.
- R9: With `wr_ld_n`=0 and both read enables low, the selected slot appears on `dout` after the edge, zero-extended to 9 bits (high slots read as 0x000 or 0x001). The selector then advances.
- R10: A threshold write and a threshold read requested in the same cycle perform only the write. `dout` is unchanged and the selector advances by one.
- R11: While `wr_ld_n`=0, no word enters or leaves the FIFO storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 9 | Write data, or threshold value in load mode |
| wr_en_n | input | 1 | Write enable, active low |
| wr_ld_n | input | 1 | High: second write enable and normal mode; low: threshold mode |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| dout | output | 9 | Registered read data or threshold read-back |
| empty | output | 1 | No words stored |
| full | output | 1 | 512 words stored |
| almost_empty | output | 1 | Count at or below the empty threshold |
| almost_full | output | 1 | Free space at or below the full threshold |

## Verification
The assertions assume that reset is held for at least one edge before traffic starts. They also assume that every control pin is a clean level across each rising edge. The stimulus therefore changes inputs only on the falling clock edge, and it starts every scenario from a fresh reset so that the selector position is known. Simultaneous threshold read and write requests are legal for the design. They are issued deliberately only once, to exercise the write-priority rule.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
  // threshold slot order is behaviour: the selector visits them in this sequence
  typedef enum logic [1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } slot_sel_e;

  localparam int          SLOT_LO_W   = 8;
  localparam logic [7:0]  THR_RST_LO  = 8'h07;
endpackage

// File: rtl/pflag_offset_seq.sv
module pflag_offset_seq
  import pflag_fifo_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    wdata,
  input  logic          thr_wr,
  input  logic          thr_rd_req,
  output logic          thr_rd,
  output logic [DW-1:0] thr_rdata,
  output logic [AW-1:0] empty_thr_nxt,
  output logic [AW-1:0] full_thr_nxt
);
  localparam int HI_W = AW - SLOT_LO_W;

  slot_sel_e            sel;
  logic [7:0]           e_lo, f_lo, e_lo_n, f_lo_n;
  logic [HI_W-1:0]      e_hi, f_hi, e_hi_n, f_hi_n;
  logic                 step;

  // write wins over read when both are requested
  assign thr_rd = thr_rd_req & ~thr_wr;
  assign step   = thr_wr | thr_rd;

  always_comb begin
    e_lo_n = e_lo;
    e_hi_n = e_hi;
    f_lo_n = f_lo;
    f_hi_n = f_hi;
    if (thr_wr) begin
      case (sel)
        SLOT_EMPTY_LO: e_lo_n = wdata;
        SLOT_EMPTY_HI: e_hi_n = wdata[HI_W-1:0];
        SLOT_FULL_LO:  f_lo_n = wdata;
        default:       f_hi_n = wdata[HI_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel  <= SLOT_EMPTY_LO;
      e_lo <= THR_RST_LO;
      f_lo <= THR_RST_LO;
      e_hi <= '0;
      f_hi <= '0;
    end else begin
      e_lo <= e_lo_n;
      e_hi <= e_hi_n;
      f_lo <= f_lo_n;
      f_hi <= f_hi_n;
      if (step) sel <= slot_sel_e'(sel + 2'd1);
    end
  end

  always_comb begin
    case (sel)
      SLOT_EMPTY_LO: thr_rdata = {{(DW-SLOT_LO_W){1'b0}}, e_lo};
      SLOT_EMPTY_HI: thr_rdata = {{(DW-HI_W){1'b0}}, e_hi};
      SLOT_FULL_LO:  thr_rdata = {{(DW-SLOT_LO_W){1'b0}}, f_lo};
      default:       thr_rdata = {{(DW-HI_W){1'b0}}, f_hi};
    endcase
  end

  assign empty_thr_nxt = {e_hi_n, e_lo_n};
  assign full_thr_nxt  = {f_hi_n, f_lo_n};

  // R7
  sel_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (sel == slot_sel_e'($past(sel) + 2'd1)));

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sel));

  // R10
  wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_wr && thr_rd_req) |-> !thr_rd);
endmodule

// File: rtl/pflag_fifo_store.sv
module pflag_fifo_store #(
  parameter int DW    = 9,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          thr_rd,
  input  logic [DW-1:0] thr_rdata,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count_nxt
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          wr_ok, rd_ok;

  assign wr_ok = wr_req & (count != CW'(DEPTH));
  assign rd_ok = rd_req & (count != '0);
  assign count_nxt = count + CW'(wr_ok) - CW'(rd_ok);

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      dout  <= '0;
    end else begin
      count <= count_nxt;
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) begin
        rptr <= rptr + 1'b1;
        dout <= mem[rptr];
      end else if (thr_rd) begin
        dout <= thr_rdata;
      end
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R11
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_req && !rd_req) |=> $stable(count));

  // R10
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_req && !thr_rd) |=> $stable(dout));
endmodule

// File: rtl/pflag_flag_gen.sv
module pflag_flag_gen #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_nxt,
  input  logic [AW-1:0] empty_thr_nxt,
  input  logic [AW-1:0] full_thr_nxt,
  output logic          empty,
  output logic          full,
  output logic          almost_empty,
  output logic          almost_full
);
  logic ae_n, af_n;

  assign ae_n = count_nxt <= {1'b0, empty_thr_nxt};
  assign af_n = count_nxt >= (CW'(DEPTH) - {1'b0, full_thr_nxt});

  always_ff @(posedge clk) begin
    if (rst) begin
      empty        <= 1'b1;
      full         <= 1'b0;
      almost_empty <= 1'b1;
      almost_full  <= 1'b0;
    end else begin
      empty        <= (count_nxt == '0);
      full         <= (count_nxt == CW'(DEPTH));
      almost_empty <= ae_n;
      almost_full  <= af_n;
    end
  end

  // R4
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // R5
  empty_implies_ae_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> almost_empty);

  // R6
  full_implies_af_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> almost_full);
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo #(
  parameter int DW    = 9,
  parameter int DEPTH = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          wr_en_n,
  input  logic          wr_ld_n,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          wr_req, rd_req, thr_wr, thr_rd_req, thr_rd;
  logic [DW-1:0] thr_rdata;
  logic [CW-1:0] count_nxt;
  logic [AW-1:0] empty_thr_nxt, full_thr_nxt;
  logic          rd_both;

  assign rd_both    = ~rd_en_a_n & ~rd_en_b_n;
  assign wr_req     = ~wr_en_n & wr_ld_n;
  assign rd_req     = rd_both & wr_ld_n;
  assign thr_wr     = ~wr_en_n & ~wr_ld_n;
  assign thr_rd_req = rd_both & ~wr_ld_n;

  pflag_offset_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .wdata(din[7:0]),
    .thr_wr(thr_wr), .thr_rd_req(thr_rd_req), .thr_rd(thr_rd),
    .thr_rdata(thr_rdata),
    .empty_thr_nxt(empty_thr_nxt), .full_thr_nxt(full_thr_nxt)
  );

  pflag_fifo_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
    .clk(clk), .rst(rst), .din(din),
    .wr_req(wr_req), .rd_req(rd_req),
    .thr_rd(thr_rd), .thr_rdata(thr_rdata),
    .dout(dout), .count_nxt(count_nxt)
  );

  pflag_flag_gen #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_flags (
    .clk(clk), .rst(rst), .count_nxt(count_nxt),
    .empty_thr_nxt(empty_thr_nxt), .full_thr_nxt(full_thr_nxt),
    .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  // R11
  load_mode_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ld_n |=> ($stable(empty) && $stable(full)));
endmodule

// File: tb/sim_pflag_fifo.sv
`timescale 1ns/1ps
module sim_pflag_fifo;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] din = '0;
  logic       wr_en_n = 1'b1, wr_ld_n = 1'b1, rd_en_a_n = 1'b1, rd_en_b_n = 1'b1;
  logic [8:0] dout;
  logic       empty, full, almost_empty, almost_full;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pflag_fifo u0 (
    .clk(clk), .rst(rst), .din(din), .wr_en_n(wr_en_n), .wr_ld_n(wr_ld_n),
    .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .dout(dout),
    .empty(empty), .full(full), .almost_empty(almost_empty), .almost_full(almost_full)
  );

  // vector = {op[1:0], data[8:0], expected dout[8:0]}; op 0 write, 1 read, 2 slot load, 3 slot read
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    {2'd2, 9'h003, 9'h000},   // R7 empty-low
    {2'd2, 9'h001, 9'h000},   // R7 empty-high
    {2'd2, 9'h005, 9'h000},   // R7 full-low
    {2'd2, 9'h000, 9'h000},   // R7 full-high
    {2'd3, 9'h000, 9'h003},   // R9
    {2'd3, 9'h000, 9'h001},
    {2'd3, 9'h000, 9'h005},
    {2'd3, 9'h000, 9'h000},
    {2'd0, 9'h1A5, 9'h000},   // R2
    {2'd0, 9'h05A, 9'h000},
    {2'd1, 9'h000, 9'h1A5},
    {2'd1, 9'h000, 9'h05A},
    {2'd2, 9'h0FF, 9'h000},   // R7 fifth write wraps to empty-low
    {2'd3, 9'h000, 9'h001},
    {2'd3, 9'h000, 9'h005},
    {2'd3, 9'h000, 9'h000},
    {2'd3, 9'h000, 9'h0FF}
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic op(input logic wen, input logic ld, input logic ren, input logic [8:0] d);
    din = d;
    wr_en_n = ~wen;
    wr_ld_n = ~ld;
    rd_en_a_n = ~ren;
    rd_en_b_n = ~ren;
    @(negedge clk);
    wr_en_n = 1'b1; wr_ld_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
  endtask

  task automatic do_wr(input logic [8:0] d); op(1'b1, 1'b0, 1'b0, d); endtask
  task automatic do_rd();                    op(1'b0, 1'b0, 1'b1, 9'h000); endtask
  task automatic do_ld(input logic [8:0] d); op(1'b1, 1'b1, 1'b0, d); endtask
  task automatic do_ro();                    op(1'b0, 1'b1, 1'b1, 9'h000); endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 empty", {8'h0, empty}, 9'h001);
    chk("R1 full", {8'h0, full}, 9'h000);
    chk("R1 almost_empty", {8'h0, almost_empty}, 9'h001);
    chk("R1 almost_full", {8'h0, almost_full}, 9'h000);
    chk("R1 dout", dout, 9'h000);
    // R3 read while empty ignored
    do_rd();
    chk("R3 empty read dout", dout, 9'h000);
    chk("R3 empty read flag", {8'h0, empty}, 9'h001);

    // table walk (R2, R7, R9)
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][19:18])
        2'd0: do_wr(VEC[i][17:9]);
        2'd1: begin do_rd(); chk("R2 fifo read", dout, VEC[i][8:0]); end
        2'd2: do_ld(VEC[i][17:9]);
        default: begin do_ro(); chk("R7/R9 slot read", dout, VEC[i][8:0]); end
      endcase
    end

    // R1 defaults read back
    do_reset();
    do_ro(); chk("R1 empty-low default", dout, 9'h007);
    do_ro(); chk("R1 empty-high default", dout, 9'h000);
    do_ro(); chk("R1 full-low default", dout, 9'h007);
    do_ro(); chk("R1 full-high default", dout, 9'h000);

    // thresholds E=2, F=3; high slots given 0x1FE keep only bit 0
    do_ld(9'h002); do_ld(9'h1FE); do_ld(9'h003); do_ld(9'h1FE);
    chk("R11 load keeps empty", {8'h0, empty}, 9'h001);
    do_ro(); chk("R9 empty-low", dout, 9'h002);
    do_ro(); chk("R9 high bits zero", dout, 9'h000);
    do_ro(); chk("R9 full-low", dout, 9'h003);
    do_ro(); chk("R9 full-high", dout, 9'h000);

    for (int i = 0; i < 512; i++) begin
      do_wr(9'(i));
      if (i == 0) chk("R4 not empty", {8'h0, empty}, 9'h000);
      if (i == 1) chk("R5 ae at count 2", {8'h0, almost_empty}, 9'h001);
      if (i == 2) chk("R5 ae at count 3", {8'h0, almost_empty}, 9'h000);
      if (i == 507) chk("R6 af at count 508", {8'h0, almost_full}, 9'h000);
      if (i == 508) chk("R6 af at count 509", {8'h0, almost_full}, 9'h001);
      if (i == 510) chk("R4 not full at 511", {8'h0, full}, 9'h000);
    end
    chk("R4 full at 512", {8'h0, full}, 9'h001);
    do_wr(9'h1FF);
    chk("R3 full after extra write", {8'h0, full}, 9'h001);
    do_ro();
    chk("R9 slot read with data", dout, 9'h002);
    chk("R11 slot read keeps full", {8'h0, full}, 9'h001);
    for (int i = 0; i < 512; i++) begin
      do_rd();
      chk("R2/R3 drain order", dout, 9'(i));
    end
    chk("R4 empty after drain", {8'h0, empty}, 9'h001);
    chk("R5 ae after drain", {8'h0, almost_empty}, 9'h001);
    chk("R6 af after drain", {8'h0, almost_full}, 9'h000);
    do_rd();
    chk("R3 empty read holds dout", dout, 9'h1FF);

    // R8 partial sequence resumes
    do_reset();
    do_ld(9'h010); do_ld(9'h000);
    do_wr(9'h0AB);
    do_ld(9'h020);
    do_ro(); chk("R8 full-high next", dout, 9'h000);
    do_ro(); chk("R8 empty-low kept", dout, 9'h010);
    do_ro(); chk("R8 empty-high kept", dout, 9'h000);
    do_ro(); chk("R8 resumed at full-low", dout, 9'h020);
    do_rd(); chk("R11 fifo word intact", dout, 9'h0AB);

    // R10 simultaneous slot write and read
    do_reset();
    op(1'b1, 1'b1, 1'b1, 9'h144);
    chk("R10 dout unchanged", dout, 9'h000);
    do_ro(); chk("R10 single advance", dout, 9'h000);
    do_ro(); chk("R10 full-low", dout, 9'h007);
    do_ro(); chk("R10 full-high", dout, 9'h000);
    do_ro(); chk("R10 write landed", dout, 9'h044);
    do_ld(9'h1FF);
    do_ro(); do_ro(); do_ro(); do_ro();
    chk("R9 high slot one bit", dout, 9'h001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule